// File: doc/BRIEF.md
# Address-Decode General-Purpose Output

This block drives one general-purpose output pin. An 8-bit control register, which software can write but not read back, is loaded through a simple register-write port. A separate two-bit mode input picks how that register drives the pin. In direct mode the pin is the inverse of the register's top bit. In decode mode the pin is an active-low comparator. It goes low while ISA address lines SA9–SA3 equal the lower seven register bits. In gated decode mode that comparison is also qualified by the active-low I/O read strobe.

A direction input, set elsewhere in the chip, drives the output enable for the pin's tri-state driver. The address compare and the mode selection are combinational, so the pin follows the address bus within the same cycle. Only the control register is clocked. The block contains no register index decoding. The surrounding logic supplies a write strobe that is already qualified for this register.

Top module: `gpo_pin_ctrl`

## Requirements
- R1: After reset the control register holds 00h, so the pin is high in direct mode and low in decode mode while the address bits are all zero.
- R2: When `cfg_we` is 1 at a rising clock edge, the register takes `cfg_wdata` at that edge. When `cfg_we` is 0, the register and the pin do not change, whatever `cfg_wdata` holds.
- R3: With `mode_sel` = 2'b00 (direct), register bit 7 = 1 drives `pin_o` to 0, and bit 7 = 0 drives `pin_o` to 1.
- R4: With `mode_sel` = 2'b01 (decode), `pin_o` is 0 exactly when `sa_addr` (SA9 at bit 6 down to SA3 at bit 0) equals register bits 6..0. Otherwise `pin_o` is 1.
- R5: In either decode mode, register bit 7 has no effect on `pin_o`.
- R6: With `mode_sel` = 2'b10 (gated decode), `pin_o` is 0 only when the address matches and `io_rd_n` is 0. Otherwise `pin_o` is 1.
- R7: `mode_sel` = 2'b11 behaves exactly like direct mode.
- R8: `pin_oe` equals `dir_out` (1 = drive the pin). The direction input has no effect on the value of `pin_o`.
- R9: The decode output follows address changes within the same cycle, with no clock edge in between. The pin goes low when the address comes to match and returns high when the match ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Write data: bit 7 direct level, bits 6..0 address key |
| mode_sel | input | 2 | 00 direct, 01 decode, 10 decode gated by read, 11 direct |
| dir_out | input | 1 | 1 = pin is an output |
| sa_addr | input | 7 | Address lines SA9..SA3 (SA9 at bit 6) |
| io_rd_n | input | 1 | Active-low I/O read command |
| pin_o | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench uses address patterns that differ from the key in only the top or only the bottom bit. A compare that dropped or swapped an address line would still report a match on those patterns. It changes the address between clock edges, so a comparator that had been registered would show a stale level. It keeps the key bits fixed and flips register bit 7 in decode mode, and drives a matching address with the read strobe both idle and active in gated mode. A design that leaked the direct bit, or that ignored or inverted the gate, would drive the wrong level. It also writes data with the strobe low, sets mode 3, and clears the direction input. These catch a register that loads unconditionally, a missing fall-through of mode 3 to direct, and a direction input that leaks into the pin value.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  typedef enum logic [1:0] {
    GPO_DIRECT     = 2'b00,
    GPO_DECODE     = 2'b01,
    GPO_DECODE_RD  = 2'b10,
    GPO_DIRECT_ALT = 2'b11
  } gpo_mode_e;

  // Active-low pin level from a raw condition: asserted means pin low.
  function automatic logic active_low(input logic asserted);
    return ~asserted;
  endfunction
endpackage

// File: rtl/gpo_ctrl_reg.sv
module gpo_ctrl_reg #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  localparam logic [REG_W-1:0] RESET_VAL = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET_VAL;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/gpo_addr_cmp.sv
module gpo_addr_cmp #(
  parameter int CMP_W = 7
) (
  input  logic [CMP_W-1:0] addr,
  input  logic [CMP_W-1:0] key,
  input  logic             rd_n,
  output logic             hit_raw,
  output logic             hit_rd
);
  logic [CMP_W-1:0] bit_eq;

  // Per-line equality, reduced below.
  for (genvar i = 0; i < CMP_W; i++) begin : g_eq
    assign bit_eq[i] = ~(addr[i] ^ key[i]);
  end

  function automatic logic all_set(input logic [CMP_W-1:0] v);
    return &v;
  endfunction

  assign hit_raw = all_set(bit_eq);
  assign hit_rd  = hit_raw & ~rd_n;
endmodule

// File: rtl/gpo_out_mux.sv
module gpo_out_mux
  import gpo_pkg::*;
(
  input  gpo_mode_e mode,
  input  logic      direct_bit,
  input  logic      hit_raw,
  input  logic      hit_rd,
  output logic      pin
);
  always_comb begin
    unique case (mode)
      GPO_DECODE:    pin = active_low(hit_raw);
      GPO_DECODE_RD: pin = active_low(hit_rd);
      default:       pin = active_low(direct_bit);
    endcase
  end
endmodule

// File: rtl/gpo_pin_ctrl.sv
module gpo_pin_ctrl
  import gpo_pkg::*;
#(
  parameter int CMP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CMP_W:0]   cfg_wdata,
  input  logic [1:0]       mode_sel,
  input  logic             dir_out,
  input  logic [CMP_W-1:0] sa_addr,
  input  logic             io_rd_n,
  output logic             pin_o,
  output logic             pin_oe
);
  localparam int REG_W = CMP_W + 1;

  logic [REG_W-1:0] ctrl_q;
  logic             addr_hit;
  logic             addr_hit_rd;
  gpo_mode_e        mode;

  assign mode = gpo_mode_e'(mode_sel);

  gpo_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (ctrl_q)
  );

  gpo_addr_cmp #(.CMP_W(CMP_W)) u_cmp (
    .addr    (sa_addr),
    .key     (ctrl_q[CMP_W-1:0]),
    .rd_n    (io_rd_n),
    .hit_raw (addr_hit),
    .hit_rd  (addr_hit_rd)
  );

  gpo_out_mux u_mux (
    .mode       (mode),
    .direct_bit (ctrl_q[CMP_W]),
    .hit_raw    (addr_hit),
    .hit_rd     (addr_hit_rd),
    .pin        (pin_o)
  );

  assign pin_oe = dir_out;
endmodule

// File: rtl/gpo_pin_ctrl_chk.sv
module gpo_pin_ctrl_chk #(
  parameter int CMP_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CMP_W:0]   cfg_wdata,
  input logic [1:0]       mode_sel,
  input logic             dir_out,
  input logic [CMP_W-1:0] sa_addr,
  input logic             io_rd_n,
  input logic             pin_o,
  input logic             pin_oe,
  input logic [CMP_W:0]   ctrl_q,
  input logic             addr_hit
);
  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (ctrl_q == $past(cfg_wdata)));

  assert_no_write_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(ctrl_q));

  assert_direct_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00) |-> (pin_o != ctrl_q[CMP_W]));

  assert_decode_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01) |-> (pin_o == (sa_addr != ctrl_q[CMP_W-1:0])));

  assert_gate_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel == 2'b10) && io_rd_n) |-> pin_o);

  assert_gate_read_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel == 2'b10) && !io_rd_n && addr_hit) |-> !pin_o);

  assert_alt_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |-> (pin_o != ctrl_q[CMP_W]));

  assert_oe_follows_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_out |-> !pin_oe);
endmodule

bind gpo_pin_ctrl gpo_pin_ctrl_chk #(.CMP_W(CMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .mode_sel  (mode_sel),
  .dir_out   (dir_out),
  .sa_addr   (sa_addr),
  .io_rd_n   (io_rd_n),
  .pin_o     (pin_o),
  .pin_oe    (pin_oe),
  .ctrl_q    (ctrl_q),
  .addr_hit  (addr_hit)
);

// File: tb/gpo_pin_ctrl_test.sv
module gpo_pin_ctrl_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_we = 0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] mode_sel = 2'b00;
  logic       dir_out = 1;
  logic [6:0] sa_addr = '0;
  logic       io_rd_n = 1;
  logic       pin_o, pin_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] model_reg = 8'h00;

  always #2.5 clk = ~clk;

  gpo_pin_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode_sel(mode_sel), .dir_out(dir_out), .sa_addr(sa_addr),
    .io_rd_n(io_rd_n), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // Bench view of the expected pin level.
  function automatic logic expect_pin(input logic [1:0] m, input logic [7:0] r,
                                      input logic [6:0] a, input logic rdn);
    logic same;
    same = (a ^ r[6:0]) == 7'd0;
    if (m == 2'b01)      return same ? 1'b0 : 1'b1;
    else if (m == 2'b10) return (same && rdn == 1'b0) ? 1'b0 : 1'b1;
    else                 return r[7] ? 1'b0 : 1'b1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_pin(input string req);
    #1;
    check(req, pin_o, expect_pin(mode_sel, model_reg, sa_addr, io_rd_n));
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    model_reg = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    model_reg = 8'h00;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    mode_sel = 2'b00; sa_addr = 7'h00;
    check_pin("R1 direct after reset");
    check("R1 direct after reset high", pin_o, 1'b1);
    mode_sel = 2'b01;
    #1 check("R1 decode zero key", pin_o, 1'b0);
    mode_sel = 2'b00;
  endtask

  task automatic t_direct();
    mode_sel = 2'b00;
    write_reg(8'h80);
    check("R3 bit7 set low", pin_o, 1'b0);
    write_reg(8'h7F);
    check("R3 bit7 clear high", pin_o, 1'b1);
    check_pin("R2 loaded value");
  endtask

  task automatic t_alt_direct();
    mode_sel = 2'b11;
    write_reg(8'h80);
    #1 check("R7 mode3 bit7 set", pin_o, 1'b0);
    write_reg(8'h00);
    #1 check("R7 mode3 bit7 clear", pin_o, 1'b1);
  endtask

  task automatic t_decode();
    mode_sel = 2'b01;
    write_reg(8'h55);
    sa_addr = 7'h55; #1 check("R4 exact match low", pin_o, 1'b0);
    sa_addr = 7'h54; #1 check("R4 lsb differs high", pin_o, 1'b1);
    sa_addr = 7'h15; #1 check("R4 msb differs high", pin_o, 1'b1);
    sa_addr = 7'h2A; check_pin("R4 inverse pattern");
  endtask

  task automatic t_decode_ignores_bit7();
    mode_sel = 2'b01;
    write_reg(8'hD5);
    sa_addr = 7'h55; #1 check("R5 bit7 set match low", pin_o, 1'b0);
    sa_addr = 7'h56; #1 check("R5 bit7 set mismatch high", pin_o, 1'b1);
    mode_sel = 2'b10; io_rd_n = 0; sa_addr = 7'h55;
    #1 check("R5 gated bit7 set match", pin_o, 1'b0);
    io_rd_n = 1;
  endtask

  task automatic t_same_cycle();
    mode_sel = 2'b01;
    write_reg(8'h3C);
    @(posedge clk); #1;
    sa_addr = 7'h3C; #0.5 check("R9 low without edge", pin_o, 1'b0);
    sa_addr = 7'h3D; #0.5 check("R9 high without edge", pin_o, 1'b1);
  endtask

  task automatic t_gated();
    mode_sel = 2'b10;
    write_reg(8'h0F);
    sa_addr = 7'h0F; io_rd_n = 1; #1 check("R6 match no read high", pin_o, 1'b1);
    io_rd_n = 0; #1 check("R6 match read low", pin_o, 1'b0);
    sa_addr = 7'h0E; #1 check("R6 read no match high", pin_o, 1'b1);
    io_rd_n = 1;
  endtask

  task automatic t_no_write();
    mode_sel = 2'b00;
    write_reg(8'h00);
    @(negedge clk);
    cfg_wdata = 8'hFF; cfg_we = 0;
    @(negedge clk); @(negedge clk);
    check("R2 no strobe no change", pin_o, 1'b1);
    mode_sel = 2'b01; sa_addr = 7'h00;
    #1 check("R2 key still zero", pin_o, 1'b0);
  endtask

  task automatic t_direction();
    mode_sel = 2'b00;
    write_reg(8'h80);
    dir_out = 0; #1;
    check("R8 oe off", pin_oe, 1'b0);
    check("R8 value unchanged", pin_o, 1'b0);
    dir_out = 1; #1;
    check("R8 oe on", pin_oe, 1'b1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_direct();
    t_alt_direct();
    t_decode();
    t_decode_ignores_bit7();
    t_same_cycle();
    t_gated();
    t_no_write();
    t_direction();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule